// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two normalized single-precision floating-point words and returns a correctly rounded single-precision product together with overflow, underflow and inexact flags. The result sign is the exclusive OR of the operand signs. The two stored exponents are added, which gives a sum that carries the bias twice, and a single subtraction of the bias restores excess-127 form. The 24-bit significands, hidden leading one included, are multiplied one bit per cycle by shift and add. The 48-bit product is then normalized with at most one right shift and rounded to 24 bits from a guard bit, a round bit and a sticky bit under one of four rounding modes.

A caller presents both operands and a rounding mode and raises `start` for one cycle while `busy` is low. The block latches the inputs, and the inputs are then free to change. The result appears on the output registers together with a one-cycle `done` pulse, and it stays there until the next result. An operand whose exponent field is zero counts as a zero. In that case the multiply is skipped and a signed zero is returned on the next cycle. Denormal, infinite and NaN operands are outside the block's scope.

Top module: `fp_mul_unit`

## Requirements
- R1: When `start` is high while `busy` is low, the operands and mode are latched and `busy` rises. For two nonzero operands `done` pulses high for one cycle exactly 25 clock edges after the start edge. A `start` raised while `busy` is high is ignored and does not alter the running result.
- R2: Bit 31 of the product is the exclusive OR of bit 31 of the two operands, for every result including zero and infinity.
- R3: The result exponent field equals expA + expB − 127. It is one higher when the significand product is 2 or more. Bits 30:23 hold the exponent.
- R4: The significand product is formed from both 24-bit significands with the hidden one restored. When the discarded bits are zero, bits 22:0 hold the exact upper fraction bits of the normalized product.
- R5: Rounding mode 0 rounds to nearest. An exact halfway case rounds to an even least significant bit.
- R6: Mode 1 rounds toward plus infinity, mode 2 toward minus infinity, and mode 3 toward zero (truncation). Modes 1 and 2 increment the magnitude only when the result sign matches the direction and some discarded bit is set.
- R7: A rounding increment that carries out of the 24-bit significand shifts the significand right by one and adds one to the exponent.
- R8: A final exponent of 255 or more gives signed infinity (exponent 255, fraction 0) and sets both the overflow flag and the inexact flag.
- R9: A final exponent of 0 or less gives a signed zero and sets both the underflow flag and the inexact flag.
- R10: An operand with exponent field 0 gives a signed zero with all flags clear, and `done` follows one clock edge after the start edge.
- R11: Outside overflow and underflow, the inexact flag is set exactly when some bit below the kept 24-bit significand was nonzero.
- R12: The product and flags change only on the cycle that `done` is high, and after reset they are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when not busy |
| opA | input | 32 | First operand, single-precision |
| opB | input | 32 | Second operand, single-precision |
| rndMode | input | 2 | 0 nearest-even, 1 toward +inf, 2 toward −inf, 3 toward zero |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when a new result is registered |
| product | output | 32 | Rounded product |
| ovfFlag | output | 1 | Result overflowed to infinity |
| unfFlag | output | 1 | Result underflowed to zero |
| inexFlag | output | 1 | Result differs from the exact product |

## Verification
The multiplier is exercised first with exactly representable products whose significands stay below 2 or reach 2. These tell apart a missing bias subtraction, a missing normalizing shift and a wrong sign. One halfway product is run through all four rounding modes with both signs, which separates nearest-even from the directed modes and shows whether a directed mode looks at the sign. A significand product just below 2 isolates the carry out of rounding. Products with very large and very small exponents, and zero-exponent operands, cover the saturating and flushing paths. A batch of random operands with random modes is then compared against a behavioural integer model of the exact product.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_POS    = 2'd1,
    RND_TO_NEG    = 2'd2,
    RND_TO_ZERO   = 2'd3
  } rnd_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } fpm_ctrl_s;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      opZero,
  output fpm_ctrl_s ctl,
  output logic      busy
);
  localparam int CNT_W = $clog2(MANT_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MANT_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_FIN} state_e;
  state_e state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = opZero ? ST_FIN : ST_MUL;
      end
      ST_MUL: begin
        ctl.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIN;
      end
      ST_FIN: begin
        ctl.finish = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)      stepCnt <= '0;
      else if (ctl.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  fpm_ctrl_s                   ctl,
  input  logic [EXP_W+FRAC_W:0]       opA,
  input  logic [EXP_W+FRAC_W:0]       opB,
  input  logic [1:0]                  rndMode,
  output logic                        opZero,
  output logic [EXP_W+FRAC_W:0]       product,
  output logic                        ovfFlag,
  output logic                        unfFlag,
  output logic                        inexFlag,
  output logic                        done
);
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = 2 * MANT_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  logic [EXP_W-1:0] expA, expB;
  assign expA   = opA[WORD_W-2 -: EXP_W];
  assign expB   = opB[WORD_W-2 -: EXP_W];
  assign opZero = (expA == '0) || (expB == '0);

  // Latched operation state
  logic              signR, zeroR;
  logic [1:0]        modeR;
  logic [EXP_W:0]    expSumR;   // doubly biased sum
  logic [PROD_W-1:0] mcandW, acc;
  logic [MANT_W-1:0] mplier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signR <= 1'b0; zeroR <= 1'b0; modeR <= '0; expSumR <= '0;
      mcandW <= '0; acc <= '0; mplier <= '0;
    end else if (ctl.load) begin
      signR   <= opA[WORD_W-1] ^ opB[WORD_W-1];
      zeroR   <= opZero;
      modeR   <= rndMode;
      expSumR <= {1'b0, expA} + {1'b0, expB};
      mcandW  <= {{MANT_W{1'b0}}, 1'b1, opA[FRAC_W-1:0]};
      mplier  <= {1'b1, opB[FRAC_W-1:0]};
      acc     <= '0;
    end else if (ctl.step) begin
      if (mplier[0]) acc <= acc + mcandW;
      mcandW <= mcandW << 1;
      mplier <= mplier >> 1;
    end
  end

  // Normalize, then split off guard / round / sticky
  logic              hiBit, guardB, roundB, stickyB, lsb, anyLost, incr, carryOut;
  logic [MANT_W-1:0] keep, lowBits;
  logic [MANT_W:0]   mantSum;
  logic [FRAC_W-1:0] fracOut;
  int                expInt;

  always_comb begin
    hiBit   = acc[PROD_W-1];
    keep    = hiBit ? acc[PROD_W-1 -: MANT_W] : acc[PROD_W-2 -: MANT_W];
    lowBits = hiBit ? acc[MANT_W-1:0] : {acc[MANT_W-2:0], 1'b0};
    guardB  = lowBits[MANT_W-1];
    roundB  = lowBits[MANT_W-2];
    stickyB = |lowBits[MANT_W-3:0];
    lsb     = keep[0];
    anyLost = guardB | roundB | stickyB;
    unique case (rnd_e'(modeR))
      RND_NEAR_EVEN: incr = guardB & (roundB | stickyB | lsb);
      RND_TO_POS:    incr = ~signR & anyLost;
      RND_TO_NEG:    incr = signR & anyLost;
      default:       incr = 1'b0;
    endcase
    mantSum  = {1'b0, keep} + (MANT_W+1)'(incr);
    carryOut = mantSum[MANT_W];
    fracOut  = carryOut ? mantSum[FRAC_W:1] : mantSum[FRAC_W-1:0];
    expInt   = int'(expSumR) - BIAS + int'(hiBit) + int'(carryOut);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0; ovfFlag <= 1'b0; unfFlag <= 1'b0; inexFlag <= 1'b0; done <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.finish) begin
        if (zeroR) begin
          product <= {signR, {(WORD_W-1){1'b0}}};
          {ovfFlag, unfFlag, inexFlag} <= 3'b000;
        end else if (expInt >= EXP_TOP) begin
          product <= {signR, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          {ovfFlag, unfFlag, inexFlag} <= 3'b101;
        end else if (expInt <= 0) begin
          product <= {signR, {(WORD_W-1){1'b0}}};
          {ovfFlag, unfFlag, inexFlag} <= 3'b011;
        end else begin
          product <= {signR, expInt[EXP_W-1:0], fracOut};
          {ovfFlag, unfFlag, inexFlag} <= {2'b00, anyLost};
        end
      end
    end
  end
endmodule

// File: rtl/fp_mul_unit.sv
module fp_mul_unit
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [1:0]            rndMode,
  output logic                  busy,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] product,
  output logic                  ovfFlag,
  output logic                  unfFlag,
  output logic                  inexFlag
);
  localparam int MANT_W = FRAC_W + 1;

  fpm_ctrl_s ctl;
  logic      opZero;

  fpm_ctrl #(.MANT_W(MANT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .opZero(opZero),
    .ctl(ctl), .busy(busy)
  );

  fpm_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .opA(opA), .opB(opB),
    .rndMode(rndMode), .opZero(opZero), .product(product),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .inexFlag(inexFlag), .done(done)
  );
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [EXP_W+FRAC_W:0] product,
  input logic                  ovfFlag,
  input logic                  unfFlag,
  input logic                  inexFlag
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  assert_start_accepted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_from_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_ovf_infinity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag |-> (product[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && inexFlag);

  assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unfFlag |-> (product[WORD_W-2:0] == '0) && inexFlag && !ovfFlag);

  assert_result_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product) && $stable({ovfFlag, unfFlag, inexFlag}));
endmodule

bind fp_mul_unit fpm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpm_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .product(product), .ovfFlag(ovfFlag), .unfFlag(unfFlag), .inexFlag(inexFlag)
);

// File: tb/fp_mul_unit_bench.sv
`timescale 1ns/1ps
module fp_mul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  rndMode = '0;
  logic        busy, done, ovfFlag, unfFlag, inexFlag;
  logic [31:0] product;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_mul_unit u_fp_mul_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .rndMode(rndMode), .busy(busy), .done(done), .product(product),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .inexFlag(inexFlag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model of the exact product: {ovf, unf, inex, word}
  function automatic logic [34:0] refMul(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    logic sgn;
    longint unsigned p, keepV, remV, half;
    int sh, e;
    bit up, inex;
    sgn = a[31] ^ b[31];
    if (a[30:23] == 0 || b[30:23] == 0) return {3'b000, sgn, 31'b0};
    p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
    sh = p[47] ? 24 : 23;
    e = int'(a[30:23]) + int'(b[30:23]) - 127 + (p[47] ? 1 : 0);
    keepV = p >> sh;
    remV = p & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    case (m)
      2'd0: up = (remV > half) || (remV == half && keepV[0]);
      2'd1: up = !sgn && remV != 0;
      2'd2: up = sgn && remV != 0;
      default: up = 0;
    endcase
    inex = (remV != 0);
    keepV = keepV + (up ? 1 : 0);
    if (keepV == (64'd1 << 24)) begin keepV = keepV >> 1; e++; end
    if (e >= 255) return {3'b101, sgn, 8'hFF, 23'b0};
    if (e <= 0) return {3'b011, sgn, 31'b0};
    return {2'b00, inex, sgn, e[7:0], keepV[22:0]};
  endfunction

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                       input string req, input bit midStart);
    logic [34:0] expv;
    int cnt, expLat;
    logic [31:0] held;
    expv = refMul(a, b, m);
    expLat = (a[30:23] == 0 || b[30:23] == 0) ? 1 : 25;
    @(negedge clk);
    opA = a; opB = b; rndMode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; opA = ~a; opB = 32'h3F800000; rndMode = ~m;
    cnt = 0;
    while (1) begin
      @(negedge clk);
      cnt++;
      if (midStart && cnt == 5) start = 1'b1;   // R1: ignored while busy
      if (midStart && cnt == 6) start = 1'b0;
      if (done || cnt > 60) break;
    end
    check(cnt == expLat, expLat == 1 ? "R10 latency" : "R1 latency", cnt, expLat);
    check(product == expv[31:0], req, product, expv[31:0]);
    check({ovfFlag, unfFlag, inexFlag} == expv[34:32], {req, " flags"},
          {ovfFlag, unfFlag, inexFlag}, expv[34:32]);
    held = product;
    @(negedge clk);
    check(!done && product == held, "R12 hold", {done, product[30:0]}, {1'b0, held[30:0]});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && product == 0 && !ovfFlag && !unfFlag && !inexFlag,
          "R12 reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle", {busy, done}, 0);

    runOp(32'h3FC00000, 32'h40000000, 2'd0, "R4 exact", 0);     // 1.5*2 = 3
    runOp(32'hBFC00000, 32'h40000000, 2'd0, "R2 sign", 0);
    runOp(32'hBF800000, 32'hC0A00000, 2'd0, "R2 neg*neg", 0);
    runOp(32'h3FC00000, 32'h3FC00000, 2'd0, "R3 hi-bit", 0);    // 2.25
    runOp(32'h42F60000, 32'h3D000000, 2'd0, "R3 bias", 0);
    runOp(32'h3FC00000, 32'h40000000, 2'd0, "R1 mid-start", 1);
    // halfway product under every mode and both signs
    for (int m = 0; m < 4; m++) begin
      runOp(32'h3F800001, 32'h3FC00000, 2'(m), m == 0 ? "R5 tie+" : "R6 tie+", 0);
      runOp(32'hBF800001, 32'h3FC00000, 2'(m), m == 0 ? "R5 tie-" : "R6 tie-", 0);
      runOp(32'h3F800003, 32'h3F800005, 2'(m), "R11 small lost", 0);
    end
    runOp(32'h3FB504F3, 32'h3FB504F3, 2'd1, "R7 carry", 0);
    runOp(32'hBFB504F3, 32'h3FB504F3, 2'd2, "R7 carry neg", 0);
    runOp(32'h3FB504F3, 32'h3FB504F3, 2'd3, "R7 no carry", 0);
    runOp(32'h7F000000, 32'h7F000000, 2'd0, "R8 overflow", 0);
    runOp(32'hFF000000, 32'h40000000, 2'd3, "R8 overflow neg", 0);
    runOp(32'h00800000, 32'h00800000, 2'd0, "R9 underflow", 0);
    runOp(32'hA0000000, 32'h1F000000, 2'd1, "R9 underflow neg", 0);
    runOp(32'h00000000, 32'h40400000, 2'd0, "R10 zero", 0);
    runOp(32'h80000000, 32'h3F800000, 2'd0, "R10 neg zero", 0);
    runOp(32'h3F812345, 32'h807FFFFF, 2'd1, "R10 zero exp", 0);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      ra[30:23] = 8'(64 + ($urandom % 128));
      rb[30:23] = 8'(64 + ($urandom % 128));
      runOp(ra, rb, 2'($urandom), "R4 random", 0);
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule